// File: doc/BRIEF.md
# Reservation monitor for load-reserved / store-conditional

This block keeps a small table of address reservations for the hardware contexts that share one memory. A context is named by a core number and a thread number. When a context issues a load-reserved, the block records the reservation granule of the address against that context. Each context holds at most one reservation. A repeated load-reserved from the same context moves its reservation to the new granule.

Every write-type request is looked up against the table: plain stores and store-conditionals. A store-conditional passes only when the same context still holds a reservation on the same granule. Any write clears every reservation on its granule, whoever holds it and whether or not the write passes. The block answers one cycle after each request with registered flags. One flag is the store-conditional outcome. The other is a write enable for the memory array beside it. The table update made by one request is seen by the request in the next cycle.

Top module: `rsv_monitor`

## Requirements
- R1: After a synchronous active-high reset, `sc_done`, `sc_pass` and `wr_en` are 0 and no reservation is held, so a store-conditional fails.
- R2: A load-reserved (`req_kind` = 2'b00) from a context without an entry creates a reservation, and a later store-conditional from that context to the same granule passes with `wr_en` = 1.
- R3: A second load-reserved from a context that holds a reservation replaces its granule. A store-conditional to the old granule then fails, and one to the new granule passes.
- R4: Addresses are compared by granule, meaning address bits above bit GRAN_LG-1. Two addresses that differ only in the low GRAN_LG bits (default 3) match.
- R5: An ordinary load (`req_kind` = 2'b11) leaves the table unchanged and drives `wr_en` and `sc_done` to 0.
- R6: A plain store (`req_kind` = 2'b01) always gives `wr_en` = 1 and `sc_done` = 0.
- R7: A store-conditional (`req_kind` = 2'b10) gives `sc_done` = 1. `sc_pass` and `wr_en` equal 1 only when an entry matches both the granule and the context `{req_core, req_thread}`; otherwise both are 0.
- R8: Every write clears all reservations on its granule, for all contexts, even when a store-conditional fails. Reservations on other granules are kept.
- R9: When all ENTRIES slots are in use and a context without an entry issues a load-reserved, entry 0 is overwritten and its former owner loses its reservation.
- R10: Outputs are registered one cycle after the request. With `req_valid` = 0 all three outputs are 0. Back-to-back requests see each other's table updates.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | A request is present this cycle |
| req_kind | input | 2 | 00 load-reserved, 01 plain store, 10 store-conditional, 11 ordinary load |
| req_addr | input | ADDR_W | Byte address of the request |
| req_core | input | CORE_W | Core number of the requester |
| req_thread | input | THREAD_W | Thread number of the requester |
| sc_done | output | 1 | Previous cycle carried a store-conditional |
| sc_pass | output | 1 | That store-conditional succeeded |
| wr_en | output | 1 | Memory write permitted for the previous request |

## Verification
The bench drives directed sequences and then a long random mix over a few granules and many contexts. A bench-side model checks every cycle. The directed sequences separate several cases:
- the same context from a different context on one granule;
- the same granule from a neighbouring one;
- a replaced reservation from a kept one;
- a passing write from a failing one, both of which must clear reservations.

A fill of the table followed by a ninth context shows which slot is given up. The random phase packs writes and reservations back to back, so it exposes any stale view of the table between consecutive requests.

// File: rtl/rsv_pkg.sv
package rsv_pkg;
  typedef enum logic [1:0] {
    K_LR = 2'b00,
    K_ST = 2'b01,
    K_SC = 2'b10,
    K_LD = 2'b11
  } req_kind_e;
endpackage

// File: rtl/rsv_match.sv
module rsv_match #(
  parameter int N     = 8,
  parameter int TAG_W = 29,
  parameter int CTX_W = 4
) (
  input  logic [N-1:0]     ent_vld,
  input  logic [TAG_W-1:0] ent_tag [N],
  input  logic [CTX_W-1:0] ent_ctx [N],
  input  logic [TAG_W-1:0] look_tag,
  input  logic [CTX_W-1:0] look_ctx,
  output logic [N-1:0]     tag_hit,
  output logic [N-1:0]     own_hit,
  output logic             pair_any
);
  // one comparator pair per slot, all in parallel
  for (genvar i = 0; i < N; i++) begin : g_cmp
    assign tag_hit[i] = ent_vld[i] && (ent_tag[i] == look_tag);
    assign own_hit[i] = ent_vld[i] && (ent_ctx[i] == look_ctx);
  end
  assign pair_any = |(tag_hit & own_hit);
endmodule

// File: rtl/rsv_alloc.sv
module rsv_alloc #(
  parameter int N = 8
) (
  input  logic [N-1:0] ent_vld,
  input  logic [N-1:0] own_hit,
  output logic [N-1:0] slot_oh
);
  logic found;
  always_comb begin
    slot_oh = '0;
    found   = 1'b0;
    if (|own_hit) begin
      slot_oh = own_hit;            // reuse the context's own slot
    end else begin
      for (int i = 0; i < N; i++) begin
        if (!found && !ent_vld[i]) begin
          slot_oh[i] = 1'b1;
          found      = 1'b1;
        end
      end
      if (!found) slot_oh[0] = 1'b1; // table full: give up slot 0
    end
  end
endmodule

// File: rtl/rsv_table.sv
module rsv_table #(
  parameter int N     = 8,
  parameter int TAG_W = 29,
  parameter int CTX_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             do_lr,
  input  logic             do_wr,
  input  logic [N-1:0]     slot_oh,
  input  logic [N-1:0]     tag_hit,
  input  logic [TAG_W-1:0] new_tag,
  input  logic [CTX_W-1:0] new_ctx,
  output logic [N-1:0]     vld_q,
  output logic [TAG_W-1:0] tag_q [N],
  output logic [CTX_W-1:0] ctx_q [N]
);
  for (genvar i = 0; i < N; i++) begin : g_ent
    always_ff @(posedge clk) begin
      if (rst)                        vld_q[i] <= 1'b0;
      else if (do_wr && tag_hit[i])   vld_q[i] <= 1'b0;
      else if (do_lr && slot_oh[i])   vld_q[i] <= 1'b1;
    end

    always_ff @(posedge clk) begin
      if (do_lr && slot_oh[i]) begin
        tag_q[i] <= new_tag;
        ctx_q[i] <= new_ctx;
      end
    end

    a_r8_write_clears: assert property (@(posedge clk) disable iff (rst)
      (do_wr && tag_hit[i]) |=> !vld_q[i]);
    a_r2_slot_filled: assert property (@(posedge clk) disable iff (rst)
      (do_lr && slot_oh[i]) |=> (vld_q[i] && tag_q[i] == $past(new_tag)
                                 && ctx_q[i] == $past(new_ctx)));
  end

  a_r2_one_slot: assert property (@(posedge clk) disable iff (rst)
    do_lr |-> ($countones(slot_oh) == 1));
endmodule

// File: rtl/rsv_monitor.sv
module rsv_monitor #(
  parameter int ENTRIES  = 8,
  parameter int ADDR_W   = 32,
  parameter int CORE_W   = 2,
  parameter int THREAD_W = 2,
  parameter int GRAN_LG  = 3
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                req_valid,
  input  logic [1:0]          req_kind,
  input  logic [ADDR_W-1:0]   req_addr,
  input  logic [CORE_W-1:0]   req_core,
  input  logic [THREAD_W-1:0] req_thread,
  output logic                sc_done,
  output logic                sc_pass,
  output logic                wr_en
);
  import rsv_pkg::*;

  localparam int TAG_W = ADDR_W - GRAN_LG;
  localparam int CTX_W = CORE_W + THREAD_W;

  req_kind_e        kind;
  logic [TAG_W-1:0] tag;
  logic [CTX_W-1:0] ctx;
  logic             unused_low;
  logic             do_lr, do_wr, do_sc, pass_c;

  logic [ENTRIES-1:0] vld_q, tag_hit, own_hit, slot_oh;
  logic [TAG_W-1:0]   tag_q [ENTRIES];
  logic [CTX_W-1:0]   ctx_q [ENTRIES];
  logic               pair_any;

  assign kind       = req_kind_e'(req_kind);
  assign tag        = req_addr[ADDR_W-1:GRAN_LG];
  assign unused_low = ^req_addr[GRAN_LG-1:0];
  assign ctx        = {req_core, req_thread};
  assign do_lr      = req_valid && (kind == K_LR);
  assign do_sc      = req_valid && (kind == K_SC);
  assign do_wr      = do_sc || (req_valid && (kind == K_ST));
  assign pass_c     = (kind == K_ST) || pair_any;

  rsv_match #(.N(ENTRIES), .TAG_W(TAG_W), .CTX_W(CTX_W)) u_match (
    .ent_vld (vld_q),
    .ent_tag (tag_q),
    .ent_ctx (ctx_q),
    .look_tag(tag),
    .look_ctx(ctx),
    .tag_hit (tag_hit),
    .own_hit (own_hit),
    .pair_any(pair_any)
  );

  rsv_alloc #(.N(ENTRIES)) u_alloc (
    .ent_vld(vld_q),
    .own_hit(own_hit),
    .slot_oh(slot_oh)
  );

  rsv_table #(.N(ENTRIES), .TAG_W(TAG_W), .CTX_W(CTX_W)) u_table (
    .clk    (clk),
    .rst    (rst),
    .do_lr  (do_lr),
    .do_wr  (do_wr),
    .slot_oh(slot_oh),
    .tag_hit(tag_hit),
    .new_tag(tag),
    .new_ctx(ctx),
    .vld_q  (vld_q),
    .tag_q  (tag_q),
    .ctx_q  (ctx_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      sc_done <= 1'b0;
      sc_pass <= 1'b0;
      wr_en   <= 1'b0;
    end else begin
      sc_done <= do_sc;
      sc_pass <= do_sc && pair_any;
      wr_en   <= do_wr && pass_c;
    end
  end

  a_r6_store_writes: assert property (@(posedge clk) disable iff (rst)
    (req_valid && kind == K_ST) |=> (wr_en && !sc_done));
  a_r7_sc_gates_write: assert property (@(posedge clk) disable iff (rst)
    do_sc |=> (sc_done && (wr_en == sc_pass)));
  a_r5_load_quiet: assert property (@(posedge clk) disable iff (rst)
    (req_valid && kind == K_LD) |=> (!wr_en && !sc_done));
  a_r10_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> (!wr_en && !sc_done && !sc_pass));
  a_r7_pass_needs_sc: assert property (@(posedge clk) disable iff (rst)
    sc_pass |-> sc_done);
endmodule

// File: tb/test_rsv_monitor.sv
`timescale 1ns/100ps
module test_rsv_monitor;
  localparam int ENT = 8;
  localparam int GL  = 3;

  logic        clk = 1'b0;
  logic        rst;
  logic        req_valid;
  logic [1:0]  req_kind;
  logic [31:0] req_addr;
  logic [1:0]  req_core;
  logic [1:0]  req_thread;
  logic        sc_done, sc_pass, wr_en;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  // behavioural model: list of (valid, context, granule)
  bit mv   [ENT];
  int mctx [ENT];
  int mgr  [ENT];

  always #2.5 clk = ~clk;

  rsv_monitor #(.ENTRIES(ENT), .GRAN_LG(GL)) i_rsv_monitor (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_kind(req_kind),
    .req_addr(req_addr), .req_core(req_core), .req_thread(req_thread),
    .sc_done(sc_done), .sc_pass(sc_pass), .wr_en(wr_en)
  );

  task automatic compare(input string tag, input bit ed, input bit ep, input bit ew);
    checks++;
    if (sc_done !== ed || sc_pass !== ep || wr_en !== ew) begin
      errors++;
      $display("FAIL %s actual done/pass/we=%b%b%b expected=%b%b%b",
               tag, sc_done, sc_pass, wr_en, ed, ep, ew);
    end
  endtask

  // one request per clock; model computes the answer, then checks next negedge
  task automatic step(input bit v, input int k, input int a, input int c,
                      input int t, input string tag);
    bit ed = 0, ep = 0, ew = 0;
    int g   = a >> GL;
    int cx  = c * 4 + t;
    req_valid  = v;
    req_kind   = 2'(k);
    req_addr   = 32'(a);
    req_core   = 2'(c);
    req_thread = 2'(t);
    if (v && k == 0) begin
      int slot = -1;
      for (int i = 0; i < ENT; i++) if (slot < 0 && mv[i] && mctx[i] == cx) slot = i;
      for (int i = 0; i < ENT; i++) if (slot < 0 && !mv[i]) slot = i;
      if (slot < 0) slot = 0;
      mv[slot] = 1; mctx[slot] = cx; mgr[slot] = g;
    end else if (v && (k == 1 || k == 2)) begin
      bit hit = 0;
      for (int i = 0; i < ENT; i++)
        if (mv[i] && mgr[i] == g && mctx[i] == cx) hit = 1;
      for (int i = 0; i < ENT; i++)
        if (mv[i] && mgr[i] == g) mv[i] = 0;
      ed = (k == 2);
      ep = (k == 2) && hit;
      ew = (k == 1) || hit;
    end
    @(negedge clk);
    compare(tag, ed, ep, ew);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++; checks++;
      $display("FAIL R10 watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < ENT; i++) mv[i] = 0;
    rst = 1; req_valid = 0; req_kind = 0; req_addr = 0; req_core = 0; req_thread = 0;
    repeat (3) @(negedge clk);
    compare("R1 reset outputs", 0, 0, 0);
    rst = 0;
    step(1, 2, 'h100, 0, 0, "R1 sc after reset");
    // R2 / R4
    step(1, 0, 'h100, 0, 0, "R2 lr");
    step(1, 2, 'h104, 0, 0, "R2 R4 sc same granule");
    step(1, 2, 'h100, 0, 0, "R8 sc after own clear");
    // R3
    step(1, 0, 'h200, 1, 0, "R3 lr first");
    step(1, 0, 'h300, 1, 0, "R3 lr replace");
    step(1, 2, 'h200, 1, 0, "R3 sc old granule");
    step(1, 2, 'h300, 1, 0, "R3 sc new granule");
    // R5
    step(1, 0, 'h400, 2, 1, "R5 lr");
    step(1, 3, 'h400, 2, 1, "R5 ordinary load");
    step(1, 2, 'h400, 2, 1, "R5 sc still reserved");
    // R6 / R8
    step(1, 0, 'h500, 0, 1, "R8 lr a");
    step(1, 0, 'h500, 0, 2, "R8 lr b");
    step(1, 0, 'h508, 3, 3, "R8 lr other granule");
    step(1, 1, 'h503, 1, 1, "R6 plain store");
    step(1, 2, 'h500, 0, 1, "R8 sc a cleared");
    step(1, 2, 'h500, 0, 2, "R8 sc b cleared");
    step(1, 2, 'h50C, 3, 3, "R8 R4 other granule kept");
    // R8 failed sc still clears, R7 context mismatch
    step(1, 0, 'h600, 0, 0, "R8 lr");
    step(1, 2, 'h600, 1, 1, "R7 sc wrong context");
    step(1, 2, 'h600, 0, 0, "R8 cleared by failed sc");
    step(1, 0, 'h700, 2, 2, "R7 lr");
    step(1, 2, 'h708, 2, 2, "R7 sc wrong granule");
    step(1, 2, 'h700, 2, 2, "R7 sc right granule");
    step(0, 0, 'h700, 2, 2, "R10 idle");
    // R9 fill and evict slot 0
    for (int c = 0; c < 8; c++) step(1, 0, 'h1000 + c * 'h10, c / 4, c % 4, "R9 fill");
    step(1, 0, 'h2000, 2, 0, "R9 ninth context");
    step(1, 2, 'h1000, 0, 0, "R9 evicted owner");
    step(1, 2, 'h2000, 2, 0, "R9 newcomer");
    step(1, 2, 'h1010, 0, 1, "R9 survivor");
    // R10 random back-to-back mix
    for (int n = 0; n < 600; n++) begin
      int k = $urandom_range(0, 3);
      int a = $urandom_range(0, 5) * 8 + $urandom_range(0, 7);
      step($urandom_range(0, 7) != 0, k, a, $urandom_range(0, 3),
           $urandom_range(0, 3), "R10 random mix");
    end
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule